// File: doc/BRIEF.md
# Stream Sideband Escape Decoder

This block sits at the far end of a narrow data pipe. Upstream, the end-of-packet flag and the byte-enable mask of a stream were folded into the data words themselves. The fold uses a marker word: its upper 32 bits hold the fixed code 0xDEADBEEF, and its low bits hold the sideband flags. The decoder restores an ordinary AXI4-Stream with TDATA, TKEEP and TLAST. A marker word is swallowed. The flags it carries are held and attached to the one word that follows it. Every other word leaves with both flags cleared.

The word after a marker is always payload, so a payload that happens to begin with the code travels safely behind an empty marker. Both sides use valid/ready handshakes with full backpressure. The data width is a parameter. The keep width defaults to one bit per byte. Elaboration stops if the word is too narrow to hold the code, the keep field and the last bit.

Top module: `sb_unescape`

## Requirements
- R1: In the idle phase, an input word whose bits [DATA_W-1:DATA_W-32] equal 0xDEADBEEF is a marker. The decoder accepts it with in_ready=1 whatever out_ready is, and it produces no output beat (out_valid=0).
- R2: Bit 0 of a marker gives the TLAST value and bits [KEEP_W:1] give the TKEEP value. Both appear on out_last and out_keep with the next payload beat.
- R3: The word that follows a marker goes out with its data unchanged, even if it also begins with 0xDEADBEEF. It is never taken as a marker.
- R4: A word that is not a marker and does not follow one goes out unchanged, with out_last=0 and out_keep=0.
- R5: While a payload is expected, out_valid follows in_valid and in_ready follows out_ready. If out_ready is low, the beat and its flags are held until they are accepted, with no loss and no repeat.
- R6: Once the payload beat completes its output handshake, the held flags are cleared and the decoder returns to the idle phase.
- R7: A synchronous reset returns the decoder to idle and clears the held flags. A marker accepted before the reset has no effect on later words.
- R8: A random stream of beats, encoded by a reference folder, decodes back to the same data, last flags and keep masks in the same order. Some beats begin with the code, and keep is zero unless last is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Escaped input word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| out_data | output | DATA_W | Restored TDATA |
| out_keep | output | KEEP_W | Restored TKEEP |
| out_last | output | 1 | Restored TLAST |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |

## Verification
Several directed patterns are used. A plain word shows that untouched data passes with clear flags. A marker sent while out_ready is low shows that markers are absorbed without waiting on the output. A marker with flags, followed by a stalled payload, shows that flags are placed correctly and held under backpressure, and the plain word after it shows they are cleared. An empty marker followed by a code-prefixed payload tells a protected payload apart from a marker. A reset between a marker and its payload tests the reset. Random traffic through a reference folder, with about a quarter of the payloads code-prefixed and random stalls on both sides, checks that ordering and flag placement hold under arbitrary interleaving.

// File: rtl/sb_unescape_pkg.sv
package sb_unescape_pkg;

    localparam int unsigned    MARK_W    = 32;
    localparam logic [31:0]    MARK_CODE = 32'hDEAD_BEEF;

    typedef enum logic [0:0] {
        PH_IDLE    = 1'b0,
        PH_PAYLOAD = 1'b1
    } phase_t;

endpackage

// File: rtl/sb_mark_detect.sv
// Compares the top slice of a word against the marker code.
module sb_mark_detect
    import sb_unescape_pkg::*;
(
    input  logic [MARK_W-1:0] top_bits,
    output logic              is_mark
);

    always_comb begin
        is_mark = (top_bits == MARK_CODE);
    end

endmodule

// File: rtl/sb_flag_hold.sv
// Two-phase tracker: holds the flags taken from a marker until its payload leaves.
module sb_flag_hold
    import sb_unescape_pkg::*;
#(
    parameter int unsigned KEEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_mark,
    input  logic              mark_last,
    input  logic [KEEP_W-1:0] mark_keep,
    input  logic              beat_done,
    output phase_t            phase,
    output logic              held_last,
    output logic [KEEP_W-1:0] held_keep
);

    typedef struct packed {
        phase_t            phase;
        logic              last;
        logic [KEEP_W-1:0] keep;
    } hold_t;

    localparam hold_t HOLD_RESET = '{phase: PH_IDLE, last: 1'b0, keep: '0};

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        unique case (hold_q.phase)
            PH_IDLE: begin
                if (take_mark) begin
                    hold_d.phase = PH_PAYLOAD;
                    hold_d.last  = mark_last;
                    hold_d.keep  = mark_keep;
                end
            end
            PH_PAYLOAD: begin
                if (beat_done) begin
                    hold_d = HOLD_RESET;
                end
            end
            default: hold_d = HOLD_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= HOLD_RESET;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign phase     = hold_q.phase;
    assign held_last = hold_q.last;
    assign held_keep = hold_q.keep;

endmodule

// File: rtl/sb_beat_route.sv
// Steers words and handshakes by phase: markers are absorbed, data passes.
module sb_beat_route
    import sb_unescape_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned KEEP_W = 8
) (
    input  phase_t            phase,
    input  logic              is_mark,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              out_ready,
    input  logic              held_last,
    input  logic [KEEP_W-1:0] held_keep,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [KEEP_W-1:0] out_keep
);

    always_comb begin
        out_data  = in_data;
        out_valid = in_valid;
        in_ready  = out_ready;
        out_last  = 1'b0;
        out_keep  = '0;
        if (phase == PH_PAYLOAD) begin
            out_last = held_last;
            out_keep = held_keep;
        end else if (is_mark) begin
            out_valid = 1'b0;
            in_ready  = 1'b1;
        end
    end

endmodule

// File: rtl/sb_unescape.sv
module sb_unescape
    import sb_unescape_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned KEEP_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [KEEP_W-1:0] out_keep,
    output logic              out_last,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int unsigned MIN_W = MARK_W + KEEP_W + 1;

    if (DATA_W < MIN_W) begin : g_width_too_small
        $error("sb_unescape: DATA_W must be at least MARK_W + KEEP_W + 1");
    end

    logic   is_mark;
    logic   take_mark;
    logic   beat_done;
    phase_t phase;
    logic   held_last;
    logic [KEEP_W-1:0] held_keep;

    sb_mark_detect u_detect (
        .top_bits (in_data[DATA_W-1 -: MARK_W]),
        .is_mark  (is_mark)
    );

    assign take_mark = (phase == PH_IDLE) && in_valid && is_mark;
    assign beat_done = out_valid && out_ready;

    sb_flag_hold #(.KEEP_W(KEEP_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .take_mark (take_mark),
        .mark_last (in_data[0]),
        .mark_keep (in_data[KEEP_W:1]),
        .beat_done (beat_done),
        .phase     (phase),
        .held_last (held_last),
        .held_keep (held_keep)
    );

    sb_beat_route #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_route (
        .phase     (phase),
        .is_mark   (is_mark),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .held_last (held_last),
        .held_keep (held_keep),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_keep  (out_keep)
    );

endmodule

// File: rtl/sb_unescape_chk.sv
module sb_unescape_chk
    import sb_unescape_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned KEEP_W = DATA_W / 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [KEEP_W-1:0] out_keep,
    input logic              out_last,
    input logic              out_valid,
    input logic              out_ready
);

    // Port-level model of the phase: a marker accepted while idle opens a payload slot.
    logic              pend_q;
    logic              cap_last_q;
    logic [KEEP_W-1:0] cap_keep_q;
    logic              mark_seen;

    assign mark_seen = (in_data[DATA_W-1 -: MARK_W] == MARK_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            cap_last_q <= 1'b0;
            cap_keep_q <= '0;
        end else if (!pend_q && in_valid && in_ready && mark_seen) begin
            pend_q     <= 1'b1;
            cap_last_q <= in_data[0];
            cap_keep_q <= in_data[KEEP_W:1];
        end else if (pend_q && out_valid && out_ready) begin
            pend_q <= 1'b0;
        end
    end

    a_r1_mark_absorbed: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && in_valid && mark_seen) |-> (in_ready && !out_valid));

    a_r2_flags_placed: assert property (@(posedge clk) disable iff (rst)
        (pend_q && out_valid) |-> (out_last == cap_last_q && out_keep == cap_keep_q));

    a_r3_payload_verbatim: assert property (@(posedge clk) disable iff (rst)
        (pend_q && out_valid) |-> (out_data == in_data));

    a_r4_plain_clear: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && out_valid) |-> (!out_last && out_keep == '0));

    a_r5_payload_handshake: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> (out_valid == in_valid && in_ready == out_ready));

endmodule

bind sb_unescape sb_unescape_chk #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_chk (.*);

// File: tb/sb_unescape_tb.sv
`timescale 1ns/1ps
module sb_unescape_tb;

    localparam int unsigned DW     = 64;
    localparam int unsigned KW     = DW / 8;
    localparam logic [31:0] CODE   = 32'hDEAD_BEEF;
    localparam int unsigned NBEATS = 400;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          last;
        logic [KW-1:0] keep;
    } beat_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] out_data;
    logic [KW-1:0] out_keep;
    logic          out_last;
    logic          out_valid;
    logic          out_ready = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    beat_t exp_q[$];
    bit    drv_done = 1'b0;

    always #2.5 clk = ~clk;

    sb_unescape #(.DATA_W(DW), .KEEP_W(KW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_keep  (out_keep),
        .out_last  (out_last),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mark_word(input logic last, input logic [KW-1:0] keep);
        logic [DW-1:0] w;
        w = '0;
        w[DW-1 -: 32] = CODE;
        w[KW:1] = keep;
        w[0] = last;
        return w;
    endfunction

    // Drives one raw word, starting at a falling edge, until it is accepted.
    task automatic send_raw(input logic [DW-1:0] w);
        bit acc;
        in_valid = 1'b1;
        in_data  = w;
        forever begin
            #2;
            acc = in_ready;
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 1'b0;
    endtask

    // Reference folder: marks any beat with last set or a code prefix.
    task automatic send_beat(input beat_t b);
        exp_q.push_back(b);
        if (b.last || b.data[DW-1 -: 32] == CODE) send_raw(mark_word(b.last, b.keep));
        send_raw(b.data);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #2;
        // R7: reset state
        chk(out_valid == 1'b0, "R7", "out_valid after reset", DW'(out_valid), '0);
        @(negedge clk);

        // R4: plain word
        in_valid = 1'b1; in_data = 64'h1234_5678_8765_4321; out_ready = 1'b1;
        #2;
        chk(out_valid && out_data == 64'h1234_5678_8765_4321, "R4", "plain data", out_data, 64'h1234_5678_8765_4321);
        chk(!out_last && out_keep == '0, "R4", "plain flags", DW'({out_last, out_keep}), '0);
        @(negedge clk);

        // R1: marker with last=1 keep=2, output stalled
        in_data = 64'hDEAD_BEEF_0000_0005; out_ready = 1'b0;
        #2;
        chk(in_ready && !out_valid, "R1", "marker absorbed {in_ready,out_valid}", DW'({in_ready, out_valid}), DW'(2'b10));
        @(negedge clk);

        // R5: no input in payload phase
        in_valid = 1'b0;
        #2;
        chk(!out_valid, "R5", "out_valid follows in_valid", DW'(out_valid), '0);
        @(negedge clk);

        // R2 / R5: payload under backpressure
        in_valid = 1'b1; in_data = 64'h1234_5678_8765_4321;
        #2;
        chk(out_valid && !in_ready, "R5", "stalled {out_valid,in_ready}", DW'({out_valid, in_ready}), DW'(2'b10));
        chk(out_last && out_keep == KW'(2), "R2", "flags {last,keep}", DW'({out_last, out_keep}), DW'({1'b1, KW'(2)}));
        @(negedge clk);
        #2;
        chk(out_valid && out_last && out_keep == KW'(2) && out_data == 64'h1234_5678_8765_4321,
            "R5", "held beat data", out_data, 64'h1234_5678_8765_4321);
        out_ready = 1'b1;
        #0.1;
        chk(in_ready, "R5", "in_ready follows out_ready", DW'(in_ready), DW'(1));
        @(negedge clk);

        // R6: flags cleared after payload handshake
        in_data = 64'h0BAD_F00D_0000_0001;
        #2;
        chk(out_valid && !out_last && out_keep == '0, "R6", "flags cleared", DW'({out_last, out_keep}), '0);
        @(negedge clk);

        // R3: empty marker then code-prefixed payload
        in_data = 64'hDEAD_BEEF_0000_0000;
        #2;
        chk(in_ready && !out_valid, "R1", "empty marker absorbed", DW'({in_ready, out_valid}), DW'(2'b10));
        @(negedge clk);
        in_data = 64'hDEAD_BEEF_FEED_CAFE;
        #2;
        chk(out_valid && out_data == 64'hDEAD_BEEF_FEED_CAFE, "R3", "protected payload", out_data, 64'hDEAD_BEEF_FEED_CAFE);
        chk(!out_last && out_keep == '0, "R3", "protected payload flags", DW'({out_last, out_keep}), '0);
        @(negedge clk);

        // R7: reset between a marker and its payload
        in_data = 64'hDEAD_BEEF_0000_001F;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b1; in_data = 64'h0000_0000_CAFE_0001;
        #2;
        chk(out_valid && !out_last && out_keep == '0, "R7", "flags after reset", DW'({out_last, out_keep}), '0);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);

        // R8: random round trip with scoreboard
        fork
            begin : driver
                for (int i = 0; i < NBEATS; i++) begin
                    beat_t b;
                    b.data = {$urandom, $urandom};
                    if ($urandom % 4 == 0) b.data[DW-1 -: 32] = CODE;
                    b.last = ($urandom % 5 == 0);
                    b.keep = b.last ? KW'($urandom) : '0;
                    repeat ($urandom % 3) @(negedge clk);
                    send_beat(b);
                end
                drv_done = 1'b1;
            end
            begin : monitor
                forever begin
                    out_ready = ($urandom % 4 != 0);
                    #2;
                    if (out_valid && out_ready) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R8", "unexpected beat", out_data, '0);
                        end else begin
                            beat_t e;
                            e = exp_q.pop_front();
                            chk(out_data == e.data && out_last == e.last && out_keep == e.keep,
                                "R8", "round trip data", out_data, e.data);
                        end
                    end
                    @(negedge clk);
                    if (drv_done && exp_q.size() == 0) break;
                end
            end
        join

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule